// File: doc/BRIEF.md
# Dual-Mode Acquisition Sequencer

This block is the control state machine that runs data taking for one detector unit. It works in one of two run styles, chosen when a run is started. In the triggered style, an external trigger strobe or a memory-full indication ends the acquisition window. The sequencer then starts a readout and, once the readout is done, spends a fixed number of cycles flushing the front end. In the beam-gated style, the front end triggers itself. The window opens only while the beam level is high, and it closes when memory fills or the beam drops. No flush step follows the readout in this style.

A run is started either as a loop, which re-arms after every cycle, or as a single shot, which goes back to idle after one cycle. A stop command aborts at once while the sequencer is arming or acquiring. During a readout or flush, a stop is held back until the cycle ends. Pause and resume strobes freeze and restart the beam-gated machine. A busy flag tells a common synchronization board that this unit is not idle. All command, trigger and status inputs are synchronous to `clk`.

The states are Idle, Arm, Acquire, Readout and Flush. The transitions are:
- Idle→Arm on a start command.
- Arm→Acquire after one cycle in the triggered style, or when the beam is high in the gated style.
- Acquire→Readout on a window-closing event.
- Readout→Flush (triggered style) or Readout→end-of-cycle (gated style) on readout done.
- Flush→end-of-cycle after the flush count.
- End-of-cycle→Arm when looping, or →Idle for a single shot or a pending stop.
- Arm/Acquire→Idle on stop.
- Any state→Idle on reset.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is low, the sequencer is in Idle, and busy, acq_en, ro_start and flush are all 0. Reset is asynchronous, so these outputs clear immediately and do not wait for a clock edge.
- R2: In Idle, a start-loop or start-once strobe moves the sequencer to Arm at the next edge. The mode_gated input is sampled at the same edge (0 = triggered, 1 = beam-gated). If both start strobes come together, loop operation wins. All other strobes are ignored in Idle.
- R3: In the triggered style, Arm lasts exactly one cycle. Acquire then holds acq_en high until trig_in or mem_full is seen, and Readout follows at the next edge.
- R4: ro_start is high only in the first cycle of Readout. Readout then holds until ro_done is seen.
- R5: In the triggered style, ro_done moves the sequencer to Flush. Flush keeps the flush output high for exactly FLUSH_CYC cycles (default 4).
- R6: In the beam-gated style, Arm waits while beam_on is 0. Acquire moves to Readout when mem_full is seen or beam_on is 0. trig_in has no effect. ro_done ends the cycle directly, with no Flush.
- R7: At the end of a cycle, a looping run returns to Arm, and a single-shot run returns to Idle.
- R8: A stop strobe in Arm or Acquire returns the sequencer to Idle at the next edge.
- R9: A stop strobe in Readout or Flush keeps busy high until the cycle completes. The sequencer then goes to Idle, even when looping.
- R10: In the beam-gated style, a pause strobe freezes the state. A resume strobe lets it advance again from the cycle after the resume. A stop is still honoured while paused. In the triggered style, pause has no effect.
- R11: busy is 1 in every state except Idle.
- R12: acq_en is 1 only in Acquire. At most one of acq_en, ro_start and flush is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Common reset, active low, asynchronous |
| mode_gated | input | 1 | Run style for the next start: 0 triggered, 1 beam-gated |
| cmd_start_loop | input | 1 | Strobe: start a looping run |
| cmd_start_once | input | 1 | Strobe: start a single-cycle run |
| cmd_stop | input | 1 | Strobe: stop acquisition |
| cmd_pause | input | 1 | Strobe: freeze the beam-gated machine |
| cmd_resume | input | 1 | Strobe: restart the beam-gated machine |
| trig_in | input | 1 | Trigger strobe (triggered style) |
| mem_full | input | 1 | Front-end memory full |
| beam_on | input | 1 | Beam level, 1 = beam present |
| ro_done | input | 1 | Readout finished |
| acq_en | output | 1 | Acquisition window open |
| ro_start | output | 1 | One-cycle readout start |
| flush | output | 1 | Flush in progress |
| busy | output | 1 | Unit not idle |

## Verification
The properties assume the following about the inputs:
- Every input is synchronous to `clk`.
- Command strobes are one-cycle pulses.
- The beam level only changes between clock edges.

The stimulus changes inputs on the falling edge and holds each strobe for exactly one rising edge. This keeps every sampled value well defined. The pause properties also assume that the paused state only arises in a beam-gated run. The stimulus therefore issues pauses in both styles, but checks the freeze only in the gated one.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_ACQ   = 3'd2,
        ST_READ  = 3'd3,
        ST_FLUSH = 3'd4
    } seq_state_e;

endpackage

// File: rtl/acq_seq_ctl.sv
// Run-control flags: loop/once, run style, pause and deferred stop.
module acq_seq_ctl
    import acq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state,
    input  logic       start_loop,
    input  logic       start_once,
    input  logic       mode_gated,
    input  logic       cmd_stop,
    input  logic       cmd_pause,
    input  logic       cmd_resume,
    output logic       run_loop,
    output logic       run_gated,
    output logic       paused,
    output logic       stop_pend
);

    logic in_window;
    logic in_tail;

    assign in_window = (state == ST_ARM)  || (state == ST_ACQ);
    assign in_tail   = (state == ST_READ) || (state == ST_FLUSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_loop  <= 1'b0;
            run_gated <= 1'b0;
            paused    <= 1'b0;
            stop_pend <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (start_loop || start_once) begin
                run_loop  <= start_loop;
                run_gated <= mode_gated;
            end
            paused    <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (cmd_stop && in_window) begin
                paused <= 1'b0;
            end else if (cmd_pause && run_gated) begin
                paused <= 1'b1;
            end else if (cmd_resume) begin
                paused <= 1'b0;
            end
            if (cmd_stop && in_tail) begin
                stop_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/acq_seq_next.sv
// Next-state decision for the sequencer.
module acq_seq_next
    import acq_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       start_loop,
    input  logic       start_once,
    input  logic       cmd_stop,
    input  logic       trig_in,
    input  logic       mem_full,
    input  logic       beam_on,
    input  logic       ro_done,
    input  logic       run_loop,
    input  logic       run_gated,
    input  logic       paused,
    input  logic       stop_pend,
    input  logic       flush_done,
    output seq_state_e state_nxt
);

    logic       hold;
    logic       window_close;
    seq_state_e cycle_end;

    assign hold         = paused && run_gated;
    assign window_close = run_gated ? (mem_full || !beam_on) : (mem_full || trig_in);
    assign cycle_end    = (stop_pend || cmd_stop || !run_loop) ? ST_IDLE : ST_ARM;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_loop || start_once) state_nxt = ST_ARM;
            end
            ST_ARM: begin
                if (cmd_stop)                  state_nxt = ST_IDLE;
                else if (hold)                 state_nxt = ST_ARM;
                else if (!run_gated || beam_on) state_nxt = ST_ACQ;
            end
            ST_ACQ: begin
                if (cmd_stop)          state_nxt = ST_IDLE;
                else if (hold)         state_nxt = ST_ACQ;
                else if (window_close) state_nxt = ST_READ;
            end
            ST_READ: begin
                if (!hold && ro_done) state_nxt = run_gated ? cycle_end : ST_FLUSH;
            end
            ST_FLUSH: begin
                if (flush_done) state_nxt = cycle_end;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/acq_seq_flush.sv
// Counts the cycles spent in Flush.
module acq_seq_flush #(
    parameter int FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_flush,
    output logic flush_done
);

    localparam int CW = $clog2(FLUSH_CYC) + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (in_flush) cnt_q <= cnt_q + 1'b1;
        else               cnt_q <= '0;
    end

    assign flush_done = in_flush && (cnt_q == CW'(FLUSH_CYC - 1));

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_gated,
    input  logic cmd_start_loop,
    input  logic cmd_start_once,
    input  logic cmd_stop,
    input  logic cmd_pause,
    input  logic cmd_resume,
    input  logic trig_in,
    input  logic mem_full,
    input  logic beam_on,
    input  logic ro_done,
    output logic acq_en,
    output logic ro_start,
    output logic flush,
    output logic busy
);

    seq_state_e state_q;
    seq_state_e prev_q;
    seq_state_e state_nxt;
    logic       run_loop;
    logic       run_gated;
    logic       paused;
    logic       stop_pend;
    logic       flush_done;

    acq_seq_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state_q),
        .start_loop (cmd_start_loop),
        .start_once (cmd_start_once),
        .mode_gated (mode_gated),
        .cmd_stop   (cmd_stop),
        .cmd_pause  (cmd_pause),
        .cmd_resume (cmd_resume),
        .run_loop   (run_loop),
        .run_gated  (run_gated),
        .paused     (paused),
        .stop_pend  (stop_pend)
    );

    acq_seq_flush #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_flush   (state_q == ST_FLUSH),
        .flush_done (flush_done)
    );

    acq_seq_next u_next (
        .state      (state_q),
        .start_loop (cmd_start_loop),
        .start_once (cmd_start_once),
        .cmd_stop   (cmd_stop),
        .trig_in    (trig_in),
        .mem_full   (mem_full),
        .beam_on    (beam_on),
        .ro_done    (ro_done),
        .run_loop   (run_loop),
        .run_gated  (run_gated),
        .paused     (paused),
        .stop_pend  (stop_pend),
        .flush_done (flush_done),
        .state_nxt  (state_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prev_q  <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
            prev_q  <= state_q;
        end
    end

    // Output decode
    always_comb begin
        acq_en   = 1'b0;
        ro_start = 1'b0;
        flush    = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy     = 1'b0;
            ST_ARM:   ;
            ST_ACQ:   acq_en   = 1'b1;
            ST_READ:  ro_start = (prev_q != ST_READ);
            ST_FLUSH: flush    = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_stop,
    input logic trig_in,
    input logic ro_done,
    input logic beam_on,
    input logic acq_en,
    input logic ro_start,
    input logic flush,
    input logic busy,
    input logic run_gated,
    input logic paused
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!busy && !acq_en && !ro_start && !flush);
        end
    end

    // R11
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en || ro_start || flush) |-> busy);

    // R12
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acq_en, ro_start, flush}));

    // R4
    ro_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ro_start |=> !ro_start);

    // R8
    stop_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && cmd_stop) |=> !busy);

    // R3
    trig_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && !run_gated && trig_in && !cmd_stop) |=> ro_start);

    // R6
    beam_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && run_gated && !paused && !beam_on && !cmd_stop) |=> ro_start);

    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && paused && !cmd_stop) |=> acq_en);

    // R5
    flush_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush) |-> ($past(ro_done) && !run_gated));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_start && !ro_done) |=> busy);

endmodule

bind acq_sequencer acq_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stop  (cmd_stop),
    .trig_in   (trig_in),
    .ro_done   (ro_done),
    .beam_on   (beam_on),
    .acq_en    (acq_en),
    .ro_start  (ro_start),
    .flush     (flush),
    .busy      (busy),
    .run_gated (run_gated),
    .paused    (paused)
);

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FLUSH_N    = 4;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_gated = 1'b0;
    logic cmd_start_loop = 1'b0;
    logic cmd_start_once = 1'b0;
    logic cmd_stop = 1'b0;
    logic cmd_pause = 1'b0;
    logic cmd_resume = 1'b0;
    logic trig_in = 1'b0;
    logic mem_full = 1'b0;
    logic beam_on = 1'b0;
    logic ro_done = 1'b0;
    logic acq_en, ro_start, flush, busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Output vector order: {busy, acq_en, ro_start, flush}
    localparam logic [3:0] O_IDLE  = 4'b0000;
    localparam logic [3:0] O_WAIT  = 4'b1000;
    localparam logic [3:0] O_ACQ   = 4'b1100;
    localparam logic [3:0] O_RSTRT = 4'b1010;
    localparam logic [3:0] O_FLUSH = 4'b1001;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_sequencer #(.FLUSH_CYC(FLUSH_N)) u_acq_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_gated     (mode_gated),
        .cmd_start_loop (cmd_start_loop),
        .cmd_start_once (cmd_start_once),
        .cmd_stop       (cmd_stop),
        .cmd_pause      (cmd_pause),
        .cmd_resume     (cmd_resume),
        .trig_in        (trig_in),
        .mem_full       (mem_full),
        .beam_on        (beam_on),
        .ro_done        (ro_done),
        .acq_en         (acq_en),
        .ro_start       (ro_start),
        .flush          (flush),
        .busy           (busy)
    );

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {busy, acq_en, ro_start, flush};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {busy,acq_en,ro_start,flush}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic expect_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: value=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_flush(input string req);
        int n;
        n = 0;
        while (flush && n < 50) begin
            n++;
            tick();
        end
        expect_int(req, n, FLUSH_N);
    endtask

    // R1, R2: reset state and strobes ignored in Idle
    task automatic t_reset_idle;
        repeat (3) tick();
        expect_out("R1 outputs during reset", O_IDLE);
        rst_n = 1'b1;
        tick();
        expect_out("R1 idle after reset", O_IDLE);
        beam_on = 1'b1; cmd_pause = 1'b1; cmd_resume = 1'b1; cmd_stop = 1'b1;
        trig_in = 1'b1; mem_full = 1'b1; ro_done = 1'b1;
        tick();
        beam_on = 1'b0; cmd_pause = 1'b0; cmd_resume = 1'b0; cmd_stop = 1'b0;
        trig_in = 1'b0; mem_full = 1'b0; ro_done = 1'b0;
        expect_out("R2 non-start strobes ignored in idle", O_IDLE);
    endtask

    // R3, R4, R5, R7, R8, R11, R10 (pause ignored in triggered style)
    task automatic t_trig_loop;
        mode_gated = 1'b0;
        cmd_start_loop = 1'b1; tick(); cmd_start_loop = 1'b0;
        expect_out("R11 arm is busy", O_WAIT);
        tick();
        expect_out("R3 acquire after one arm cycle", O_ACQ);
        repeat (3) tick();
        expect_out("R3 acquire holds without event", O_ACQ);
        cmd_pause = 1'b1; tick(); cmd_pause = 1'b0;
        expect_out("R10 pause no effect in triggered acquire", O_ACQ);
        trig_in = 1'b1; tick(); trig_in = 1'b0;
        expect_out("R4 readout start on trigger", O_RSTRT);
        tick();
        expect_out("R4 ro_start single cycle", O_WAIT);
        repeat (3) tick();
        expect_out("R4 readout waits for done", O_WAIT);
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        expect_out("R5 flush after readout", O_FLUSH);
        count_flush("R5 flush length");
        expect_out("R7 loop returns to arm", O_WAIT);
        tick();
        expect_out("R7 loop reaches acquire again", O_ACQ);
        mem_full = 1'b1; tick(); mem_full = 1'b0;
        expect_out("R3 memory full closes triggered window", O_RSTRT);
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        count_flush("R5 flush length second cycle");
        tick();
        expect_out("R7 acquire on third loop", O_ACQ);
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        expect_out("R8 stop in acquire", O_IDLE);
    endtask

    // R6, R7 single shot in gated style
    task automatic t_gated_once;
        mode_gated = 1'b1; beam_on = 1'b0;
        cmd_start_once = 1'b1; tick(); cmd_start_once = 1'b0;
        repeat (3) tick();
        expect_out("R6 arm waits for beam", O_WAIT);
        beam_on = 1'b1; tick();
        expect_out("R6 acquire with beam", O_ACQ);
        trig_in = 1'b1; tick(); trig_in = 1'b0;
        expect_out("R6 trigger ignored in gated acquire", O_ACQ);
        beam_on = 1'b0; tick();
        expect_out("R6 beam drop forces readout", O_RSTRT);
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        expect_out("R7 single shot back to idle, no flush (R6)", O_IDLE);
    endtask

    // R6, R7, R10, R9 in gated loop
    task automatic t_gated_pause;
        mode_gated = 1'b1; beam_on = 1'b1;
        cmd_start_loop = 1'b1; tick(); cmd_start_loop = 1'b0;
        tick();
        expect_out("R6 gated loop acquire", O_ACQ);
        mem_full = 1'b1; tick(); mem_full = 1'b0;
        expect_out("R6 memory full closes gated window", O_RSTRT);
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        expect_out("R7 gated loop re-arms", O_WAIT);
        tick();
        expect_out("R7 gated loop acquire again", O_ACQ);
        cmd_pause = 1'b1; tick(); cmd_pause = 1'b0;
        beam_on = 1'b0;
        repeat (3) tick();
        expect_out("R10 paused acquire frozen despite beam drop", O_ACQ);
        cmd_resume = 1'b1; tick(); cmd_resume = 1'b0;
        expect_out("R10 resume cycle still frozen", O_ACQ);
        tick();
        expect_out("R10 advances after resume", O_RSTRT);
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        expect_out("R9 stop in readout stays busy", O_WAIT);
        tick();
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        expect_out("R9 deferred stop ends loop", O_IDLE);
    endtask

    // R9 in triggered flush, R10 stop while paused, R8 stop in arm
    task automatic t_stops;
        mode_gated = 1'b0;
        cmd_start_loop = 1'b1; tick(); cmd_start_loop = 1'b0;
        tick();
        trig_in = 1'b1; tick(); trig_in = 1'b0;
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        expect_out("R9 stop in triggered readout stays busy", O_WAIT);
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        expect_out("R9 flush still runs after deferred stop", O_FLUSH);
        count_flush("R9 flush length with stop");
        expect_out("R9 idle after flush", O_IDLE);

        mode_gated = 1'b1; beam_on = 1'b1;
        cmd_start_loop = 1'b1; tick(); cmd_start_loop = 1'b0;
        tick();
        cmd_pause = 1'b1; tick(); cmd_pause = 1'b0;
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        expect_out("R10 stop honoured while paused", O_IDLE);

        beam_on = 1'b0;
        cmd_start_once = 1'b1; tick(); cmd_start_once = 1'b0;
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        expect_out("R8 stop in arm", O_IDLE);
    endtask

    // R2 both starts, R1 async reset mid-run
    task automatic t_both_reset;
        mode_gated = 1'b0;
        cmd_start_loop = 1'b1; cmd_start_once = 1'b1; tick();
        cmd_start_loop = 1'b0; cmd_start_once = 1'b0;
        tick();
        trig_in = 1'b1; tick(); trig_in = 1'b0;
        ro_done = 1'b1; tick(); ro_done = 1'b0;
        count_flush("R5 flush length with both starts");
        expect_out("R2 loop wins over once", O_WAIT);
        tick();
        expect_out("R2 acquire after re-arm", O_ACQ);
        rst_n = 1'b0;
        #1;
        expect_out("R1 asynchronous reset clears outputs", O_IDLE);
        tick();
        rst_n = 1'b1;
        tick();
        expect_out("R1 idle after mid-run reset", O_IDLE);
    endtask

    initial begin
        t_reset_idle();
        t_trig_loop();
        t_gated_once();
        t_gated_pause();
        t_stops();
        t_both_reset();
        summary();
        $finish;
    end

endmodule